// File: doc/BRIEF.md
# Byte-Wide Static Memory Bus Front End

This block is a clocked model of the slave side of a byte-wide asynchronous static memory bus. The three active-low strobes (chip select, write strobe, output enable) are oversampled on the system clock. The address, write data and a write-lock input from the supply supervisor are oversampled with them. The block decodes read and write cycles from these sampled levels and keeps the bytes in an internal array. It drives read data with a separate drive-enable, so a pad ring or a bench can build the tri-state pin from it.

A write window is open while chip select and write strobe are both low. Whichever of the two falls later opens it, and whichever rises first closes it. The byte stored is the data and address sampled in the last cycle of the window. The output driver is released whenever the write strobe is low. It also stays released for a whole chip-select period that began with the write strobe already low. The write lock blocks both reads and writes but leaves the stored contents untouched. Three one-cycle error pulses report protocol faults: an address change inside a window, a window shorter than a set number of cycles, and a new window opened before the write strobe has recovered long enough.

Top module: `sram_bus_front`

## Requirements
- R1: With chip select low, output enable low, write strobe high and write lock low, `rd_drive_o` goes to 1 and `rd_data_o` shows the byte stored at the sampled address. This happens SYNC_STAGES+1 clock edges after the inputs settle.
- R2: A byte is written only while chip select and write strobe are both sampled low. The write commits when the first of the two rises, whether that is the write strobe or chip select.
- R3: The committed byte and address are those sampled in the last cycle of the window. Earlier data values inside the same window are discarded.
- R4: While the write strobe is sampled low, `rd_drive_o` is 0, even with chip select and output enable low.
- R5: If the write strobe is low when chip select falls (before or together), `rd_drive_o` stays 0 until chip select rises again, even after the write strobe returns high.
- R6: A change of the sampled address while a window stays open raises `addr_err_o` for exactly one cycle.
- R7: A window that closes after fewer than MIN_WIN sampled cycles raises `win_err_o` for one cycle. Windows of MIN_WIN or more cycles raise nothing.
- R8: After a commit, a new window that opens before REC_CYC sampled cycles of write strobe high have passed raises `rec_err_o` for one cycle.
- R9: While the write lock is sampled high, no window opens, nothing is written and `rd_drive_o` is 0.
- R10: Bytes stored before the write lock was raised read back unchanged after it is released.
- R11: During and right after reset, `rd_drive_o`, `rd_data_o` and all three error outputs are 0.
- R12: Whenever `rd_drive_o` is 0, `rd_data_o` is 0.
- R13: Only the low DEPTH_LOG2 address bits select a byte. Addresses that differ only in the upper bits reach the same location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 8 | Write data from the bus |
| rd_data_o | output | 8 | Read data, 0 when not driving |
| rd_drive_o | output | 1 | Read-data driver enable |
| sel_n_i | input | 1 | Chip select, active low |
| wstb_n_i | input | 1 | Write strobe, active low |
| oen_n_i | input | 1 | Output enable, active low |
| wlock_i | input | 1 | Write lock from the supply supervisor, active high |
| addr_err_o | output | 1 | Pulse: address moved inside a write window |
| win_err_o | output | 1 | Pulse: write window too short |
| rec_err_o | output | 1 | Pulse: write recovery time violated |

## Verification
The bench builds the block with DEPTH_LOG2 = 4, MIN_WIN = 3, REC_CYC = 2 and SYNC_STAGES = 2. The 16-byte array lets one sweep write and read back every location, closing the window alternately by write strobe and by chip select. A full 19-bit address with high bits set then shows the aliasing onto those same locations. The small MIN_WIN and REC_CYC let a one-cycle window and a one-cycle recovery gap each be driven as clear violations, while the normal writes stay far enough beyond both limits to show that no flag fires falsely.

// File: rtl/sram_bus_pkg.sv
// Package: shared widths and the type of one sampled bus snapshot.
// Assumes a byte-wide data bus.
package sram_bus_pkg;

    localparam int DATA_W = 8;

    // One oversampled view of the control strobes (all levels as on the pins).
    typedef struct packed {
        logic wlock;
        logic oen_n;
        logic wstb_n;
        logic sel_n;
    } bus_ctl_t;

    localparam bus_ctl_t CTL_IDLE = '{wlock: 1'b0, oen_n: 1'b1, wstb_n: 1'b1, sel_n: 1'b1};

endpackage

// File: rtl/sram_bus_sync.sv
// Module: multi-stage sampling chain for a bundle of asynchronous inputs.
// Every bit passes through STAGES flops. Assumes the bus holds its levels
// for more than STAGES clock cycles, so skew between bits inside the bundle
// lasts at most one sampled cycle.
module sram_bus_sync #(
    parameter int              W       = 8,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // Purpose: first capture of the raw pins.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= RST_VAL;
                else        stg[g] <= d_i;
            end
        end else begin : g_next
            // Purpose: further settling stage.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= RST_VAL;
                else        stg[g] <= stg[g-1];
            end
        end
    end

    assign q_o = stg[STAGES-1];

endmodule

// File: rtl/sram_bus_cycle.sv
// Module: write-window decoder and protocol checker.
// Opens a window while select and strobe are both low and lock is low. It
// latches address and data every open cycle and commits on the close,
// unless the lock caused the close. It times window width and write
// recovery, flags address movement inside a window, and holds the
// output-release lock for strobe-first cycles. Assumes synchronised inputs.
module sram_bus_cycle #(
    parameter int ADDR_W  = 19,
    parameter int IDX_W   = 8,
    parameter int MIN_WIN = 3,
    parameter int REC_CYC = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            sel_s,
    input  logic                            wstb_s,
    input  logic                            wlock_s,
    input  logic [ADDR_W-1:0]               addr_s,
    input  logic [sram_bus_pkg::DATA_W-1:0] wdata_s,
    output logic                            wr_stb_o,
    output logic [IDX_W-1:0]                wr_idx_o,
    output logic [sram_bus_pkg::DATA_W-1:0] wr_data_o,
    output logic                            hold_off_o,
    output logic                            addr_err_o,
    output logic                            win_err_o,
    output logic                            rec_err_o
);
    import sram_bus_pkg::*;

    localparam int WC_W = $clog2(MIN_WIN + 1) + 1;
    localparam int RC_W = $clog2(REC_CYC + 1) + 1;
    localparam logic [WC_W-1:0] WC_MAX = {WC_W{1'b1}};
    localparam logic [WC_W-1:0] WC_MIN = WC_W'(MIN_WIN);
    localparam logic [RC_W-1:0] RC_LOAD = RC_W'(REC_CYC);

    logic              win, win_q, sel_q, close_ok, open_now;
    logic [ADDR_W-1:0] lat_addr;
    logic [DATA_W-1:0] lat_data;
    logic [WC_W-1:0]   win_cnt;
    logic [RC_W-1:0]   rec_cnt;
    logic              hold_q;

    assign win      = !sel_s && !wstb_s && !wlock_s;
    assign open_now = win && !win_q;
    assign close_ok = win_q && !win && !wlock_s;

    // Purpose: remember last window state and last select level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q <= 1'b0;
            sel_q <= 1'b1;
        end else begin
            win_q <= win;
            sel_q <= sel_s;
        end
    end

    // Purpose: latch address and data on every open cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_addr <= '0;
            lat_data <= '0;
        end else if (win) begin
            lat_addr <= addr_s;
            lat_data <= wdata_s;
        end
    end

    // Purpose: count open cycles of the current window, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                          win_cnt <= '0;
        else if (open_now)                   win_cnt <= WC_W'(1);
        else if (win && win_cnt != WC_MAX)   win_cnt <= win_cnt + 1'b1;
    end

    // Purpose: count down write-strobe-high cycles after a commit.
    always_ff @(posedge clk) begin
        if (!rst_n)                          rec_cnt <= '0;
        else if (close_ok)                   rec_cnt <= RC_LOAD;
        else if (wstb_s && rec_cnt != '0)    rec_cnt <= rec_cnt - 1'b1;
    end

    // Purpose: hold the output driver off for a strobe-first select period.
    always_ff @(posedge clk) begin
        if (!rst_n)                 hold_q <= 1'b0;
        else if (sel_s)             hold_q <= 1'b0;
        else if (sel_q && !wstb_s)  hold_q <= 1'b1;
    end

    // Purpose: register the three protocol fault pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_err_o <= 1'b0;
            win_err_o  <= 1'b0;
            rec_err_o  <= 1'b0;
        end else begin
            addr_err_o <= win && win_q && (addr_s != lat_addr);
            win_err_o  <= close_ok && (win_cnt < WC_MIN);
            rec_err_o  <= open_now && (rec_cnt != '0);
        end
    end

    assign wr_stb_o   = close_ok;
    assign wr_idx_o   = lat_addr[IDX_W-1:0];
    assign wr_data_o  = lat_data;
    assign hold_off_o = hold_q;

    // R6
    addr_err_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_err_o |-> $past(!sel_s && !wstb_s));

    // R7
    win_err_on_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_err_o |-> $past(wr_stb_o));

endmodule

// File: rtl/sram_bus_store.sv
// Module: byte storage array with one synchronous write port and one
// combinational read port. The array is not reset: contents persist
// across reset and write lock. Assumes a power-of-two depth.
module sram_bus_store #(
    parameter int IDX_W = 8
) (
    input  logic                            clk,
    input  logic                            wr_en,
    input  logic [IDX_W-1:0]                wr_idx,
    input  logic [sram_bus_pkg::DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]                rd_idx,
    output logic [sram_bus_pkg::DATA_W-1:0] rd_data
);
    import sram_bus_pkg::*;

    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Purpose: store one byte on a commit strobe.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_data;
    end

    assign rd_data = mem[rd_idx];

endmodule

// File: rtl/sram_bus_front.sv
// Module: top of the static memory bus front end.
// Samples the pins, decodes write windows, keeps the array and drives
// registered read data with a drive-enable. Assumes the pins are held
// steady for several clock cycles per bus phase.
module sram_bus_front #(
    parameter int ADDR_W      = 19,
    parameter int DEPTH_LOG2  = 8,
    parameter int SYNC_STAGES = 2,
    parameter int MIN_WIN     = 3,
    parameter int REC_CYC     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [7:0]        bus_wdata_i,
    output logic [7:0]        rd_data_o,
    output logic              rd_drive_o,
    input  logic              sel_n_i,
    input  logic              wstb_n_i,
    input  logic              oen_n_i,
    input  logic              wlock_i,
    output logic              addr_err_o,
    output logic              win_err_o,
    output logic              rec_err_o
);
    import sram_bus_pkg::*;

    localparam int CTL_W = $bits(bus_ctl_t);
    localparam int BND_W = CTL_W + ADDR_W + DATA_W;
    localparam logic [BND_W-1:0] BND_RST = {CTL_IDLE, {ADDR_W{1'b0}}, {DATA_W{1'b0}}};

    bus_ctl_t          ctl_s;
    logic [ADDR_W-1:0] addr_s;
    logic [DATA_W-1:0] wdata_s;
    logic [BND_W-1:0]  bnd_raw, bnd_s;

    logic                  wr_stb, hold_off, rd_ok;
    logic [DEPTH_LOG2-1:0] wr_idx;
    logic [DATA_W-1:0]     wr_data, arr_q;
    logic                  drive_q;
    logic [DATA_W-1:0]     dout_q;

    assign bnd_raw = {wlock_i, oen_n_i, wstb_n_i, sel_n_i, bus_addr_i, bus_wdata_i};

    sram_bus_sync #(.W(BND_W), .STAGES(SYNC_STAGES), .RST_VAL(BND_RST)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (bnd_raw),
        .q_o   (bnd_s)
    );

    assign {ctl_s, addr_s, wdata_s} = bnd_s;

    sram_bus_cycle #(
        .ADDR_W (ADDR_W), .IDX_W (DEPTH_LOG2),
        .MIN_WIN(MIN_WIN), .REC_CYC(REC_CYC)
    ) cyc_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_s      (ctl_s.sel_n),
        .wstb_s     (ctl_s.wstb_n),
        .wlock_s    (ctl_s.wlock),
        .addr_s     (addr_s),
        .wdata_s    (wdata_s),
        .wr_stb_o   (wr_stb),
        .wr_idx_o   (wr_idx),
        .wr_data_o  (wr_data),
        .hold_off_o (hold_off),
        .addr_err_o (addr_err_o),
        .win_err_o  (win_err_o),
        .rec_err_o  (rec_err_o)
    );

    sram_bus_store #(.IDX_W(DEPTH_LOG2)) store_i (
        .clk     (clk),
        .wr_en   (wr_stb),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (addr_s[DEPTH_LOG2-1:0]),
        .rd_data (arr_q)
    );

    assign rd_ok = !ctl_s.sel_n && !ctl_s.oen_n && ctl_s.wstb_n && !ctl_s.wlock && !hold_off;

    // Purpose: register the read driver enable and the read byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drive_q <= 1'b0;
            dout_q  <= '0;
        end else begin
            drive_q <= rd_ok;
            dout_q  <= rd_ok ? arr_q : '0;
        end
    end

    assign rd_drive_o = drive_q;
    assign rd_data_o  = dout_q;

    // R4
    strobe_low_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_s.wstb_n |=> !rd_drive_o);

    // R9
    lock_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_s.wlock |=> !rd_drive_o);

    // R12
    idle_data_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_drive_o |-> (rd_data_o == '0));

    // R2
    commit_after_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> $past(!ctl_s.sel_n && !ctl_s.wstb_n));

endmodule

// File: tb/sram_bus_front_tb.sv
module sram_bus_front_tb_top;

    localparam int AW  = 19;
    localparam int DL2 = 4;
    localparam int DEP = 1 << DL2;
    localparam int REC = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wdata = '0;
    logic          sel_n = 1'b1, wstb_n = 1'b1, oen_n = 1'b1, wlock = 1'b0;
    logic [7:0]    rd_data;
    logic          rd_drive, addr_err, win_err, rec_err;

    int n_chk = 0, n_fail = 0;
    int cnt_ae = 0, cnt_we = 0, cnt_re = 0;
    logic [7:0] model [DEP];
    bit done = 0;

    typedef struct { logic [7:0] d; string tag; } exp_t;
    exp_t exp_q[$];
    event smp_ev;

    always #5 clk = ~clk;

    sram_bus_front #(.ADDR_W(AW), .DEPTH_LOG2(DL2), .SYNC_STAGES(2),
                     .MIN_WIN(3), .REC_CYC(REC)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr_i(addr), .bus_wdata_i(wdata),
        .rd_data_o(rd_data), .rd_drive_o(rd_drive),
        .sel_n_i(sel_n), .wstb_n_i(wstb_n), .oen_n_i(oen_n), .wlock_i(wlock),
        .addr_err_o(addr_err), .win_err_o(win_err), .rec_err_o(rec_err));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // error pulse monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (addr_err) cnt_ae++;
            if (win_err)  cnt_we++;
            if (rec_err)  cnt_re++;
        end
    end

    // scoreboard monitor: pops one expected read per sample event
    initial begin
        forever begin
            @(smp_ev);
            if (exp_q.size() != 0) begin
                exp_t e;
                e = exp_q.pop_front();
                chk(rd_drive == 1'b1, {e.tag, " drive"}, int'(rd_drive), 1);
                chk(rd_data == e.d, {e.tag, " data"}, int'(rd_data), int'(e.d));
            end
        end
    end

    task automatic idle();
        sel_n = 1'b1; wstb_n = 1'b1; oen_n = 1'b1;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // strobe_close=1: window closed by write strobe rising, else by select rising
    task automatic do_write(input logic [AW-1:0] a, input logic [7:0] d, input bit strobe_close);
        @(negedge clk);
        addr = a; wdata = d;
        if (strobe_close) sel_n = 1'b0; else wstb_n = 1'b0;
        @(negedge clk);
        if (strobe_close) wstb_n = 1'b0; else sel_n = 1'b0;
        wait_n(4);
        if (strobe_close) wstb_n = 1'b1; else sel_n = 1'b1;
        @(negedge clk);
        idle();
        wait_n(REC + 4);
        model[a[DL2-1:0]] = d;
    endtask

    task automatic do_read(input logic [AW-1:0] a, input logic [7:0] e, input string tag);
        exp_t x;
        @(negedge clk);
        addr = a; sel_n = 1'b0; oen_n = 1'b0; wstb_n = 1'b1;
        wait_n(5);
        x.d = e; x.tag = tag;
        exp_q.push_back(x);
        ->smp_ev;
        @(negedge clk);
        idle();
        wait_n(3);
    endtask

    initial begin
        int b;
        wait_n(5);
        // R11: reset state
        chk(rd_drive == 1'b0, "R11 drive", int'(rd_drive), 0);
        chk(rd_data == 8'h00, "R11 data", int'(rd_data), 0);
        chk({addr_err, win_err, rec_err} == 3'b000, "R11 flags",
            int'({addr_err, win_err, rec_err}), 0);
        @(negedge clk); rst_n = 1'b1;
        wait_n(3);
        chk(rd_drive == 1'b0, "R11 after release", int'(rd_drive), 0);

        // R2: sweep, alternating close by strobe and by select
        for (int i = 0; i < DEP; i++)
            do_write(AW'(i), 8'((i * 37) ^ 8'hA5), i[0]);
        // R1: read back every location
        for (int i = 0; i < DEP; i++)
            do_read(AW'(i), model[i], "R1/R2 sweep");
        chk(cnt_we == 0, "R7 no false short-window", cnt_we, 0);
        chk(cnt_re == 0, "R8 no false recovery", cnt_re, 0);
        chk(cnt_ae == 0, "R6 no false address error", cnt_ae, 0);

        // R13: upper address bits alias
        do_read(19'h40003, model[3], "R13 alias");

        // R3: data changed inside window, last value kept
        @(negedge clk); addr = 5; wdata = 8'h11; sel_n = 1'b0; wstb_n = 1'b0;
        wait_n(2); wdata = 8'h77;
        wait_n(3); wstb_n = 1'b1;
        @(negedge clk); idle(); wait_n(REC + 4);
        model[5] = 8'h77;
        do_read(5, 8'h77, "R3 last data");

        // R4: strobe low releases the driver during a read
        @(negedge clk); addr = 5; wdata = 8'h77; sel_n = 1'b0; oen_n = 1'b0;
        wait_n(5);
        chk(rd_drive == 1'b1, "R4 read before strobe", int'(rd_drive), 1);
        wstb_n = 1'b0;
        wait_n(5);
        chk(rd_drive == 1'b0, "R4 strobe low", int'(rd_drive), 0);
        chk(rd_data == 8'h00, "R12 data zero", int'(rd_data), 0);
        wstb_n = 1'b1;
        wait_n(5);
        chk(rd_drive == 1'b1, "R4 drive resumes", int'(rd_drive), 1);
        chk(rd_data == 8'h77, "R4 data resumes", int'(rd_data), 8'h77);
        idle(); wait_n(REC + 4);

        // R5: strobe falls before select, driver held off all select period
        @(negedge clk); addr = 6; wdata = 8'h3C; wstb_n = 1'b0;
        @(negedge clk); sel_n = 1'b0; oen_n = 1'b0;
        wait_n(5);
        chk(rd_drive == 1'b0, "R5 held off", int'(rd_drive), 0);
        wstb_n = 1'b1;
        wait_n(5);
        chk(rd_drive == 1'b0, "R5 still held after strobe rise", int'(rd_drive), 0);
        idle(); wait_n(REC + 4);
        model[6] = 8'h3C;
        do_read(6, 8'h3C, "R5/R2 written then readable");

        // R6: address moves inside a window
        b = cnt_ae;
        @(negedge clk); addr = 7; wdata = 8'h42; sel_n = 1'b0; wstb_n = 1'b0;
        wait_n(2); addr = 8;
        wait_n(3); wstb_n = 1'b1;
        @(negedge clk); idle(); wait_n(REC + 4);
        chk(cnt_ae == b + 1, "R6 address error", cnt_ae, b + 1);

        // R7: one-cycle window
        b = cnt_we;
        @(negedge clk); addr = 10; sel_n = 1'b0; wstb_n = 1'b0;
        @(negedge clk); wstb_n = 1'b1;
        @(negedge clk); idle(); wait_n(REC + 4);
        chk(cnt_we == b + 1, "R7 short window", cnt_we, b + 1);

        // R8: strobe high for only one cycle between windows
        b = cnt_re;
        @(negedge clk); addr = 11; sel_n = 1'b0; wstb_n = 1'b0;
        wait_n(4); wstb_n = 1'b1;
        @(negedge clk); wstb_n = 1'b0;
        wait_n(4); wstb_n = 1'b1;
        @(negedge clk); idle(); wait_n(REC + 4);
        chk(cnt_re == b + 1, "R8 recovery violation", cnt_re, b + 1);

        // R9 / R10: write lock
        do_write(9, 8'h5A, 1'b1);
        @(negedge clk); wlock = 1'b1;
        wait_n(4);
        addr = 9; sel_n = 1'b0; oen_n = 1'b0;
        wait_n(5);
        chk(rd_drive == 1'b0, "R9 lock blocks read", int'(rd_drive), 0);
        oen_n = 1'b1; wdata = 8'hFF; wstb_n = 1'b0;
        wait_n(5); wstb_n = 1'b1;
        @(negedge clk); idle(); wait_n(4);
        wlock = 1'b0; wait_n(4);
        do_read(9, 8'h5A, "R9/R10 lock ignored write, contents kept");
        do_read(3, model[3], "R10 other byte kept");

        wait_n(4);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule